// File: doc/BRIEF.md
# Multi-Channel Event Timer with Register Access

This block is a high-resolution event timer for a system that needs several independent timeouts from one shared timebase. A 64-bit main counter steps once per clock while the global enable is set. Each of a small set of comparator channels (three by default) watches that counter. When the counter reaches a channel's comparator value, the channel raises its own interrupt output.

Software programs the block through a simple register bus. The bus carries a 12-bit byte offset and moves either 4 or 8 bytes per access. Each channel is set up on its own, with these choices:
- One-shot or periodic operation. A periodic channel advances its comparator by a stored period after every hit.
- An edge interrupt, which is a one-clock pulse, or a level interrupt. A level interrupt is held in a status register until software clears it.
- Full 64-bit comparison or 32-bit comparison.

A one-time permission bit lets software load a periodic channel's comparator directly. The bit clears itself after that write. The main counter accepts writes only while the block is stopped.

Top module: `evt_timer`

## Requirements
- R1: The 64-bit word at offset 0x000 reads, in bits 31:0, vendor ID 0x1D0C in bits 31:16, bit 15 = 1 (legacy routing capable), bit 13 = 1 (64-bit counter), the index of the last channel (2 by default) in bits 12:8 and revision 0x01 in bits 7:0. Bits 63:32 hold the tick period in femtoseconds, 59604645 (0x038D7EA5), which matches 2^24 Hz.
- R2: Bit 0 of the global configuration word at 0x010 is the run enable. While it is 1 the main counter (0x0F0) increases by exactly one per clock; while it is 0 the counter holds and no channel can hit. Bit 1 is a stored, readable routing-select bit. Both bits reset to 0, as does the counter.
- R3: A write to the main counter loads it only while the run enable is 0. While running, the write is ignored and counting continues undisturbed.
- R4: Channel n's configuration word sits at 0x100 + 0x20·n. Bit 1 = level interrupt, bit 2 = interrupt enable, bit 3 = periodic and bit 6 = value-set are writable; bit 8 = 32-bit mode is also writable. Bits 4 and 5 always read 1 (periodic capable, 64-bit capable). Bits 63:32 read the route capability 0x00F00000 and ignore writes. All writable bits reset to 0.
- R5: In one-shot mode the channel hits in the clock where the counter equals its comparator (at 0x108 + 0x20·n). Its interrupt asserts one clock later, so a read of the counter during the interrupt returns comparator + 1. The comparator stays unchanged.
- R6: In periodic mode each hit adds the stored period to the comparator. A comparator write while periodic with value-set 0 stores only the period and leaves the comparator unchanged.
- R7: In one-shot mode, or when value-set is 1, a comparator write loads both the comparator and the period. Any comparator write clears value-set.
- R8: An edge channel (bit 1 = 0) drives its interrupt high for exactly one clock per hit and does not change the status word.
- R9: A level channel (bit 1 = 1) sets bit n of the status word at 0x020 on a hit and holds its interrupt high until software writes 1 to that bit. Writing 0 has no effect.
- R10: In 32-bit mode the channel compares only the low 32 bits of counter and comparator, and a periodic reload sums modulo 2^32 with bits 63:32 of the comparator cleared.
- R11: With interrupt enable 0 a hit neither raises the interrupt nor sets the status bit.
- R12: A 4-byte access with offset bit 2 = 1 reaches bits 63:32 of the addressed word, returned in bits 31:0. A 4-byte write changes only the addressed half. Offsets at or above 0x400 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counter timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe, one clock per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_wdata | input | 64 | Write data (bits 31:0 for a 4-byte access) |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | One interrupt output per channel |

## Verification
A comparator that fails to reload shows at the ports at once: the next periodic interrupt never comes, and a read of the comparator right after a hit returns the old value. A hit that lands one clock early or late moves the counter value read during the interrupt away from comparator + 1. That difference is visible on the first interrupt. A status bit stuck in the wrong state shows up on the very next read of 0x020 or as an interrupt level that does not follow the clear write. An error in 32-bit mode appears as a missing interrupt across the 2^32 wrap, or as upper comparator bits left set after a periodic reload.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = 32;

  // channel configuration bit positions
  localparam int unsigned CB_LEVEL  = 1;
  localparam int unsigned CB_IEN    = 2;
  localparam int unsigned CB_PERIOD = 3;
  localparam int unsigned CB_VALSET = 6;
  localparam int unsigned CB_NARROW = 8;

  // merge a 4- or 8-byte write into an existing 64-bit word
  function automatic logic [WORD_W-1:0] merge_wr(input logic [WORD_W-1:0] old,
                                                 input logic [WORD_W-1:0] wd,
                                                 input logic wide,
                                                 input logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[HALF_W-1:0], old[HALF_W-1:0]};
    else         return {old[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
  endfunction

  // view of a 64-bit word returned for a 4- or 8-byte read
  function automatic logic [WORD_W-1:0] read_view(input logic [WORD_W-1:0] v,
                                                  input logic wide,
                                                  input logic hi);
    if (wide)    return v;
    else if (hi) return {{HALF_W{1'b0}}, v[WORD_W-1:HALF_W]};
    else         return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  // counter-to-comparator match, full or low-half width
  function automatic logic cmp_hit(input logic [WORD_W-1:0] cnt,
                                   input logic [WORD_W-1:0] cmp,
                                   input logic narrow);
    if (narrow) return cnt[HALF_W-1:0] == cmp[HALF_W-1:0];
    else        return cnt == cmp;
  endfunction

  // periodic reload value, wrapping at 32 bits in narrow mode
  function automatic logic [WORD_W-1:0] cmp_next(input logic [WORD_W-1:0] cmp,
                                                 input logic [WORD_W-1:0] per,
                                                 input logic narrow);
    logic [HALF_W-1:0] s32;
    s32 = cmp[HALF_W-1:0] + per[HALF_W-1:0];
    if (narrow) return {{HALF_W{1'b0}}, s32};
    else        return cmp + per;
  endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] count
);

  logic load_ok;
  assign load_ok = wr_en & ~run;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (run)     count <= count + 1'b1;
    else if (load_ok) count <= merge_wr(count, wr_data, wr_wide, wr_hi);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> count == $past(count) + 64'd1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(count)); // R2
  AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en) |=> count == $past(count) + 64'd1); // R3

endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter logic [HALF_W-1:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] count,
  input  logic              cfg_we,
  input  logic              cmp_we,
  input  logic              sts_clr,
  input  logic              wr_wide,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cfg_rd,
  output logic [WORD_W-1:0] cmp_rd,
  output logic              sts,
  output logic              irq,
  output logic              hit
);

  logic              level_q, ien_q, per_q, valset_q, narrow_q;
  logic [WORD_W-1:0] cmp_q, prd_q;
  logic              pulse_q, sts_q;
  logic [WORD_W-1:0] cfg_new;
  logic              fire, direct_load;

  assign cfg_rd = {ROUTE_CAP, 23'd0, narrow_q, 1'b0, valset_q, 1'b1, 1'b1,
                   per_q, ien_q, level_q, 1'b0};
  assign cmp_rd = cmp_q;
  assign cfg_new = merge_wr(cfg_rd, wr_data, wr_wide, wr_hi);

  // named events for the checks below
  assign hit         = run & cmp_hit(count, cmp_q, narrow_q);
  assign fire        = hit & ien_q;
  assign direct_load = valset_q | ~per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      ien_q    <= 1'b0;
      per_q    <= 1'b0;
      valset_q <= 1'b0;
      narrow_q <= 1'b0;
    end else if (cfg_we) begin
      level_q  <= cfg_new[CB_LEVEL];
      ien_q    <= cfg_new[CB_IEN];
      per_q    <= cfg_new[CB_PERIOD];
      valset_q <= cfg_new[CB_VALSET];
      narrow_q <= cfg_new[CB_NARROW];
    end else if (cmp_we) begin
      valset_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      prd_q <= '0;
    end else if (cmp_we) begin
      prd_q <= merge_wr(prd_q, wr_data, wr_wide, wr_hi);
      if (direct_load) cmp_q <= merge_wr(cmp_q, wr_data, wr_wide, wr_hi);
    end else if (hit && per_q) begin
      cmp_q <= cmp_next(cmp_q, prd_q, narrow_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      pulse_q <= fire & ~level_q;
      if (fire && level_q) sts_q <= 1'b1;
      else if (sts_clr)    sts_q <= 1'b0;
    end
  end

  assign sts = sts_q;
  assign irq = level_q ? sts_q : pulse_q;

  logic unused_ch;
  assign unused_ch = ^{cfg_new[63:9], cfg_new[7], cfg_new[5:4], cfg_new[0]};

  AST_ONESHOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !per_q && !cmp_we) |=> $stable(cmp_q)); // R5
  AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q && !narrow_q && !cmp_we) |=> cmp_q == $past(cmp_q) + $past(prd_q)); // R6
  AST_VALSET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !valset_q); // R7
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !level_q && !cfg_we) |=> irq); // R8
  AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !level_q && !sts_clr) |=> $stable(sts_q)); // R8
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && level_q) |=> sts_q); // R9
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sts_clr) |=> sts_q); // R9
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q && narrow_q && !cmp_we) |=> cmp_q[63:32] == 32'd0); // R10
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !sts_q && !cfg_we) |=> !irq); // R11

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned       NUM_CH     = 3,
  parameter logic [15:0]       VENDOR_ID  = 16'h1D0C,
  parameter logic [7:0]        REV_ID     = 8'h01,
  parameter logic [HALF_W-1:0] PERIOD_FS  = 32'd59604645,
  parameter logic [HALF_W-1:0] ROUTE_CAP  = 32'h00F0_0000,
  parameter logic              LEGACY_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wide,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int unsigned WIN_BYTES = 1024;
  localparam logic [4:0]  LAST_CH   = 5'(NUM_CH - 1);
  localparam logic [6:0]  W_CAPS    = 7'd0;
  localparam logic [6:0]  W_GCFG    = 7'd2;
  localparam logic [6:0]  W_STS     = 7'd4;
  localparam logic [6:0]  W_CNT     = 7'd30;
  localparam logic [4:0]  CH_FIRST  = 5'd8;

  // address decode
  logic       in_win, hi_half, wr_ok;
  logic [6:0] word;
  logic       sel_caps, sel_gcfg, sel_sts, sel_cnt, sel_ch;
  logic [4:0] ch_idx;
  logic [1:0] ch_sub;

  assign in_win   = bus_addr < 12'(WIN_BYTES);
  assign word     = bus_addr[9:3];
  assign hi_half  = bus_addr[2] & ~bus_wide;
  assign wr_ok    = bus_valid & bus_write & in_win;
  assign sel_caps = word == W_CAPS;
  assign sel_gcfg = word == W_GCFG;
  assign sel_sts  = word == W_STS;
  assign sel_cnt  = word == W_CNT;
  assign sel_ch   = bus_addr[9:8] != 2'b00;
  assign ch_idx   = bus_addr[9:5] - CH_FIRST;
  assign ch_sub   = bus_addr[4:3];

  // global configuration
  logic [1:0]        gcfg_q;
  logic [WORD_W-1:0] gcfg_new, sts_wr;
  logic              run;

  assign gcfg_new = merge_wr({62'd0, gcfg_q}, bus_wdata, bus_wide, hi_half);
  assign sts_wr   = merge_wr('0, bus_wdata, bus_wide, hi_half);
  assign run      = gcfg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                  gcfg_q <= 2'b00;
    else if (wr_ok && sel_gcfg)  gcfg_q <= gcfg_new[1:0];
  end

  // main counter
  logic [WORD_W-1:0] count;

  evt_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .wr_en   (wr_ok & sel_cnt),
    .wr_wide (bus_wide),
    .wr_hi   (hi_half),
    .wr_data (bus_wdata),
    .count   (count)
  );

  // comparator channels
  logic [WORD_W-1:0] cfg_rd_a [NUM_CH];
  logic [WORD_W-1:0] cmp_rd_a [NUM_CH];
  logic [NUM_CH-1:0] sts_vec;
  logic [NUM_CH-1:0] ch_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic pick;
    assign pick = wr_ok & sel_ch & (ch_idx == 5'(i));

    evt_channel #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .count   (count),
      .cfg_we  (pick & (ch_sub == 2'd0)),
      .cmp_we  (pick & (ch_sub == 2'd1)),
      .sts_clr (wr_ok & sel_sts & sts_wr[i]),
      .wr_wide (bus_wide),
      .wr_hi   (hi_half),
      .wr_data (bus_wdata),
      .cfg_rd  (cfg_rd_a[i]),
      .cmp_rd  (cmp_rd_a[i]),
      .sts     (sts_vec[i]),
      .irq     (irq[i]),
      .hit     (ch_hit[i])
    );
  end

  // read path
  logic [WORD_W-1:0] raw;

  always_comb begin
    raw = '0;
    if (in_win) begin
      if (sel_caps)
        raw = {PERIOD_FS, VENDOR_ID, LEGACY_CAP, 1'b0, 1'b1, LAST_CH, REV_ID};
      else if (sel_gcfg)
        raw = {62'd0, gcfg_q};
      else if (sel_sts)
        raw = 64'(sts_vec);
      else if (sel_cnt)
        raw = count;
      else if (sel_ch) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (ch_idx == 5'(i)) begin
            if (ch_sub == 2'd0)      raw = cfg_rd_a[i];
            else if (ch_sub == 2'd1) raw = cmp_rd_a[i];
          end
        end
      end
    end
  end

  assign bus_rdata = read_view(raw, bus_wide, hi_half);

  logic unused_top;
  assign unused_top = ^{bus_addr[1:0], gcfg_new[63:2], sts_wr};

  AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_hit != '0) |-> run); // R2
  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> bus_rdata == '0); // R12

endmodule

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wide = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [2:0]  irq;

  evt_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [11:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 12'h000, 64'h0, 64'h038D7EA5_1D0CA201, 8'd1},  // R1 full word
    '{1'b0, 1'b0, 12'h004, 64'h0, 64'h00000000_038D7EA5, 8'd12}, // R12 upper half
    '{1'b0, 1'b0, 12'h000, 64'h0, 64'h00000000_1D0CA201, 8'd1},  // R1 low half
    '{1'b0, 1'b1, 12'h010, 64'h0, 64'h0, 8'd2},                  // R2 reset
    '{1'b0, 1'b1, 12'h020, 64'h0, 64'h0, 8'd9},                  // R9 reset
    '{1'b0, 1'b1, 12'h0F0, 64'h0, 64'h0, 8'd2},                  // R2 reset
    '{1'b0, 1'b1, 12'h100, 64'h0, 64'h00F00000_00000030, 8'd4},  // R4 reset
    '{1'b0, 1'b0, 12'h144, 64'h0, 64'h00000000_00F00000, 8'd12}, // R12 ch2 upper
    '{1'b1, 1'b0, 12'h100, 64'hFFFFFFFF, 64'h0, 8'd4},           // R4
    '{1'b0, 1'b1, 12'h100, 64'h0, 64'h00F00000_0000017E, 8'd4},  // R4 mask
    '{1'b1, 1'b0, 12'h104, 64'h12345678, 64'h0, 8'd4},           // R4 ro
    '{1'b0, 1'b0, 12'h104, 64'h0, 64'h00000000_00F00000, 8'd4},  // R4
    '{1'b1, 1'b1, 12'h100, 64'h0, 64'h0, 8'd4},
    '{1'b0, 1'b0, 12'h100, 64'h0, 64'h00000000_00000030, 8'd4},  // R4
    '{1'b1, 1'b1, 12'h410, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 8'd12}, // R12 alias
    '{1'b0, 1'b1, 12'h410, 64'h0, 64'h0, 8'd12},                 // R12
    '{1'b0, 1'b1, 12'h010, 64'h0, 64'h0, 8'd12},                 // R12 ignored
    '{1'b1, 1'b1, 12'h0F0, 64'h11223344_55667788, 64'h0, 8'd3},  // R3 load
    '{1'b0, 1'b0, 12'h0F4, 64'h0, 64'h00000000_11223344, 8'd12}, // R12
    '{1'b0, 1'b0, 12'h0F0, 64'h0, 64'h00000000_55667788, 8'd3},  // R3
    '{1'b1, 1'b0, 12'h0F0, 64'h0, 64'h0, 8'd12},                 // R12 half write
    '{1'b0, 1'b1, 12'h0F0, 64'h0, 64'h11223344_00000000, 8'd12}  // R12
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic w, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wide = w; bus_wdata = d; bus_valid = 1'b1; bus_write = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, input logic w, output logic [63:0] d);
    bus_addr = a; bus_wide = w;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd(input logic [11:0] a, input logic w, output logic [63:0] d);
    @(negedge clk);
    peek(a, w, d);
  endtask

  task automatic wait_irq(input int ch, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[ch] && n < limit);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] v, v1, v2;
    int n, seen;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R9 reset irq", 64'(irq), 64'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) wr(VECS[k].addr, VECS[k].wide, VECS[k].data);
      else begin
        rd(VECS[k].addr, VECS[k].wide, v);
        check64($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].exp);
      end
    end

    // R2: steps once per clock while running; R3: load ignored while running
    wr(12'h010, 1'b0, 64'h1);
    peek(12'h0F0, 1'b1, v1);
    repeat (4) @(negedge clk);
    peek(12'h0F0, 1'b1, v2);
    check64("R2 step rate", v2, v1 + 64'd4);
    peek(12'h0F0, 1'b1, v1);
    wr(12'h0F0, 1'b1, 64'd5);
    peek(12'h0F0, 1'b1, v2);
    check64("R3 write while running", v2, v1 + 64'd2);
    wr(12'h010, 1'b0, 64'h0);
    rd(12'h0F0, 1'b1, v1);
    repeat (8) @(negedge clk);
    peek(12'h0F0, 1'b1, v2);
    check64("R2 hold while stopped", v2, v1);

    // R5/R8: one-shot edge on channel 0
    wr(12'h0F0, 1'b1, 64'd100);
    wr(12'h100, 1'b0, 64'h04);
    wr(12'h108, 1'b1, 64'd110);
    wr(12'h010, 1'b0, 64'h1);
    wait_irq(0, 50, n);
    check64("R5 hit latency", 64'(n), 64'd11);
    peek(12'h0F0, 1'b1, v);
    check64("R5 counter at irq", v, 64'd111);
    peek(12'h020, 1'b1, v);
    check64("R8 status untouched", v, 64'h0);
    @(negedge clk);
    check64("R8 pulse width", 64'(irq[0]), 64'h0);
    peek(12'h108, 1'b1, v);
    check64("R5 comparator kept", v, 64'd110);
    wr(12'h010, 1'b0, 64'h0);

    // R6/R7: periodic on channel 1
    wr(12'h0F0, 1'b1, 64'd190);
    wr(12'h120, 1'b0, 64'h4C);
    wr(12'h128, 1'b0, 64'd200);
    wr(12'h128, 1'b0, 64'd50);
    rd(12'h128, 1'b1, v);
    check64("R6 period-only write", v, 64'd200);
    rd(12'h120, 1'b0, v);
    check64("R7 value-set cleared", v, 64'h3C);
    wr(12'h010, 1'b0, 64'h1);
    wait_irq(1, 100, n);
    check64("R6 first irq", 64'(irq[1]), 64'h1);
    peek(12'h0F0, 1'b1, v);
    check64("R6 counter first hit", v, 64'd201);
    peek(12'h128, 1'b1, v);
    check64("R6 reload one", v, 64'd250);
    wait_irq(1, 100, n);
    peek(12'h0F0, 1'b1, v);
    check64("R6 counter second hit", v, 64'd251);
    peek(12'h128, 1'b1, v);
    check64("R6 reload two", v, 64'd300);
    wr(12'h010, 1'b0, 64'h0);

    // R9: level on channel 2
    wr(12'h0F0, 1'b1, 64'd0);
    wr(12'h140, 1'b0, 64'h06);
    wr(12'h148, 1'b1, 64'd20);
    wr(12'h010, 1'b0, 64'h1);
    wait_irq(2, 100, n);
    peek(12'h020, 1'b1, v);
    check64("R9 status set", v, 64'h4);
    repeat (5) @(negedge clk);
    check64("R9 level held", 64'(irq[2]), 64'h1);
    wr(12'h020, 1'b0, 64'h0);
    check64("R9 write zero no effect", 64'(irq[2]), 64'h1);
    wr(12'h020, 1'b0, 64'h4);
    check64("R9 cleared irq", 64'(irq[2]), 64'h0);
    peek(12'h020, 1'b1, v);
    check64("R9 cleared status", v & 64'h4, 64'h0);
    wr(12'h010, 1'b0, 64'h0);

    // R11: interrupt enable off on channel 0
    wr(12'h140, 1'b0, 64'h0);
    wr(12'h0F0, 1'b1, 64'd0);
    wr(12'h100, 1'b0, 64'h0);
    wr(12'h108, 1'b1, 64'd10);
    wr(12'h010, 1'b0, 64'h1);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (irq[0]) seen++;
    end
    check64("R11 no irq", 64'(seen), 64'h0);
    peek(12'h020, 1'b1, v);
    check64("R11 no status", v, 64'h0);
    wr(12'h010, 1'b0, 64'h0);

    // R10: 32-bit mode across the 2^32 wrap
    wr(12'h0F0, 1'b1, 64'h00000000_FFFFFFF0);
    wr(12'h100, 1'b0, 64'h104);
    wr(12'h108, 1'b1, 64'd5);
    wr(12'h120, 1'b0, 64'h14C);
    wr(12'h128, 1'b1, 64'h00000000_FFFFFFF8);
    wr(12'h128, 1'b1, 64'h10);
    wr(12'h010, 1'b0, 64'h1);
    wait_irq(1, 100, n);
    peek(12'h0F0, 1'b1, v);
    check64("R10 narrow periodic hit", v, 64'h00000000_FFFFFFF9);
    peek(12'h128, 1'b1, v);
    check64("R10 reload wraps", v, 64'h00000000_00000008);
    wait_irq(0, 100, n);
    check64("R10 narrow one-shot irq", 64'(irq[0]), 64'h1);
    peek(12'h0F0, 1'b1, v);
    check64("R10 narrow one-shot counter", v, 64'h00000001_00000006);
    wait_irq(1, 100, n);
    peek(12'h0F0, 1'b1, v);
    check64("R10 second narrow hit", v, 64'h00000001_00000009);
    wr(12'h010, 1'b0, 64'h0);

    finish_run();
  end

endmodule